// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital side of a successive-approximation converter. Software programs it through four word-addressed registers: control, channel, result data and status. Each conversion is timed in ADC clocks, which are enable ticks derived from the system clock by a programmable divider. A conversion runs an acquisition phase of programmable length and then a fixed tail of 19 ADC clocks for the bit trials and the result write. At the final clock, the 12-bit sample presented on `sample_in` is captured into the upper half of a 32-bit result word. A status flag and the interrupt are raised at the same time.

A conversion can be launched in three ways. Software can set a start bit, an external pin can request it (sensed on the rising edge or on the level), or a continuous mode can relaunch it after every write. A dedicated channel code selects the temperature sensor. That channel always runs with the slowest timing, and the next conversion goes back to the programmed values.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x0600, the channel (address 1), data (address 2) and status (address 3) registers read 0, and `adc_busy` and `adc_irq` are low. Control bits 15:14, 2 and 0 always read 0.
- R2: Control bits [12:10] set the ADC clock divider D: 000=1, 001=2, 010=4, 011=8, 100=16, 101=32, and 110/111 also give 32.
- R3: Control bits [9:8] set the acquisition length N in ADC clocks: 00=2, 01=4, 10=8, 11=16.
- R4: A conversion keeps busy high for exactly D*(N+19) system clock cycles, starting at the edge that launches it. `adc_busy` shows this only while control bit 6 is 1.
- R5: When the channel register holds 15 (the temperature channel) at launch, the conversion uses N=16 and D=32 regardless of the control bits. A later conversion on another channel uses the programmed values again.
- R6: The result word holds the sample in bits [27:16] and zeros in [15:0]. With mode bits [4:3]=01 (differential) bits [31:28] copy sample bit 11 (two's complement). Mode codes 00, 10 and 11 leave bits [31:28] at zero (straight binary).
- R7: At the result write, status bit 0 (address 3) and `adc_irq` go high. A read of address 2 clears both, unless a new write happens in the same cycle.
- R8: Writing control with bit 0 = 1 while the written bit 7 (start enable) and bit 5 (power) are 1 launches a conversion on the following clock edge.
- R9: With bit 13 = 1 and bit 7 = 1, each rising edge on `start_pin` launches exactly one conversion. The launch comes on the third clock edge after the pin is first sampled high, however long the pin stays high.
- R10: With bit 13 = 0 and bit 7 = 1, conversions repeat back to back for as long as `start_pin` is high.
- R11: A conversion launched while bit 1 (continuous) is 1 relaunches after every write, even once bit 7 is cleared. Clearing bit 1 ends the run after the current conversion.
- R12: While bit 5 is 0 no conversion starts from any source.
- R13: A start request that arrives while a conversion is in progress is ignored. It neither alters the running conversion's timing nor queues another one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 2 clears status) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on `bus_addr` |
| start_pin | input | 1 | External conversion start request, asynchronous |
| sample_in | input | 12 | Converter output sample, captured at the result write |
| adc_busy | output | 1 | High while a conversion runs, if enabled |
| adc_irq | output | 1 | Conversion-done interrupt, mirrors status bit 0 |

## Verification
A software start lands one edge after the write that carries it. From that edge busy stays high for D*(N+19) edges, so the bench counts busy-high cycles at falling edges and compares the total with that product for every divider and acquisition code. The result word and status are due on the edge where busy falls, so they are read only after a busy falling edge has been seen. A pin start is due three edges after the pin goes high, and the bench samples busy just before and just after that edge. Checks that a request is ignored count completed conversions over a window long enough for a stray one to appear.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants, register field positions, sequencer state
// type and code-to-value decoders for the ADC conversion sequencer.
package adc_seq_pkg;

    localparam int CTRL_W = 16;

    // Control register field positions (software-visible layout).
    localparam int B_SOFT     = 0;
    localparam int B_CONT     = 1;
    localparam int B_MODE_LO  = 3;
    localparam int B_PWR      = 5;
    localparam int B_BUSY_EN  = 6;
    localparam int B_START_EN = 7;
    localparam int B_ACQ_LO   = 8;
    localparam int B_DIV_LO   = 10;
    localparam int B_EDGE     = 13;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h0600;
    localparam logic [CTRL_W-1:0] CTRL_KEEP  = 16'h3FFA;

    // Register word addresses.
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CHAN = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam logic [1:0] MODE_DIFF = 2'b01;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ACQ   = 2'd1,
        SEQ_TRIAL = 2'd2
    } seq_state_t;

    // Divider code to ratio; the two codes above /32 saturate at /32.
    function automatic logic [5:0] div_ratio(input logic [2:0] code);
        logic [5:0] r;
        case (code)
            3'd0:    r = 6'd1;
            3'd1:    r = 6'd2;
            3'd2:    r = 6'd4;
            3'd3:    r = 6'd8;
            3'd4:    r = 6'd16;
            default: r = 6'd32;
        endcase
        return r;
    endfunction

    // Acquisition code to ADC clock count.
    function automatic logic [4:0] acq_clocks(input logic [1:0] code);
        return 5'd2 << code;
    endfunction

endpackage

// File: rtl/adc_ctrl_regs.sv
// Register file: holds the control and channel registers, produces a
// one-cycle software start pulse, decodes control fields, and muxes the
// read data. Assumes single-cycle strobes; reads have no wait state.
module adc_ctrl_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] data_word,
    input  logic              status_flag,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              soft_pulse,
    output logic              data_read,
    output logic [CH_W-1:0]   chan,
    output logic              edge_mode,
    output logic [2:0]        div_code,
    output logic [1:0]        acq_code,
    output logic              start_en,
    output logic              busy_en,
    output logic              pwr_on,
    output logic [1:0]        mode,
    output logic              cont_en
);

    localparam int PAD_CTRL = DATA_W - CTRL_W;
    localparam int PAD_CHAN = DATA_W - CH_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CH_W-1:0]   chan_q;
    logic              soft_q;

    // Register writes and the software start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            chan_q <= '0;
            soft_q <= 1'b0;
        end else begin
            soft_q <= bus_wr && (bus_addr == ADDR_CTRL) && bus_wdata[B_SOFT];
            if (bus_wr && (bus_addr == ADDR_CTRL)) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (bus_wr && (bus_addr == ADDR_CHAN)) chan_q <= bus_wdata[CH_W-1:0];
        end
    end

    // Field decode of the stored control word.
    always_comb begin
        edge_mode = ctrl_q[B_EDGE];
        div_code  = ctrl_q[B_DIV_LO +: 3];
        acq_code  = ctrl_q[B_ACQ_LO +: 2];
        start_en  = ctrl_q[B_START_EN];
        busy_en   = ctrl_q[B_BUSY_EN];
        pwr_on    = ctrl_q[B_PWR];
        mode      = ctrl_q[B_MODE_LO +: 2];
        cont_en   = ctrl_q[B_CONT];
    end

    // Read data mux.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            ADDR_CHAN: bus_rdata = {{PAD_CHAN{1'b0}}, chan_q};
            ADDR_DATA: bus_rdata = data_word;
            default:   bus_rdata = {{(DATA_W-1){1'b0}}, status_flag};
        endcase
    end

    assign soft_pulse = soft_q;
    assign chan       = chan_q;
    assign data_read  = bus_rd && (bus_addr == ADDR_DATA);

    AST_SOFT_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_pulse |-> $past(bus_wr)) else $error("soft start without write"); // R8

endmodule

// File: rtl/adc_start_trig.sv
// Start pin conditioning: synchronises the asynchronous pin through
// SYNC_STAGES flops and presents either its rising edge or its level
// as a start request, as selected by edge_mode.
module adc_start_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_mode,
    output logic pin_req
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   pin_hi;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_many
            // Shift chain of synchroniser stages.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign pin_hi = sync_q[SYNC_STAGES-1];

    // Previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= pin_hi;
    end

    assign pin_req = edge_mode ? (pin_hi && !last_q) : pin_hi;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && pin_req) |=> (!edge_mode || !pin_req)) else $error("edge request held"); // R9

endmodule

// File: rtl/adc_clk_div.sv
// ADC clock divider: while run is high, emits one tick every `ratio`
// system cycles, first tick `ratio` cycles after run rises. Assumes
// ratio is held stable for the whole run.
module adc_clk_div #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);

    logic [RATIO_W-1:0] cnt_q;

    assign tick = run && (cnt_q == ratio - RATIO_W'(1));

    // Phase counter, held at zero outside a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + RATIO_W'(1);
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < ratio)) else $error("divider phase out of range"); // R2

endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: arbitrates start sources, latches the effective
// timing at launch (temperature override included), counts acquisition
// and tail ADC clocks, captures and formats the sample at the final
// clock, and keeps the status flag. Assumes tick comes from adc_clk_div
// driven by run/ratio.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int DATA_W     = 32,
    parameter int CH_W       = 4,
    parameter int TEMP_CHAN  = 15,
    parameter int EXTRA_CLKS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_pulse,
    input  logic              pin_req,
    input  logic [CH_W-1:0]   chan,
    input  logic [2:0]        div_code,
    input  logic [1:0]        acq_code,
    input  logic              start_en,
    input  logic              busy_en,
    input  logic              pwr_on,
    input  logic [1:0]        mode,
    input  logic              cont_en,
    input  logic [RES_W-1:0]  sample_in,
    input  logic              data_read,
    input  logic              tick,
    output logic              run,
    output logic [5:0]        ratio,
    output logic              busy_out,
    output logic [DATA_W-1:0] data_word,
    output logic              status_flag
);

    localparam int LOW_W  = DATA_W / 2;
    localparam int SIGN_W = DATA_W - LOW_W - RES_W;
    localparam int CNT_W  = $clog2(16 + EXTRA_CLKS + 1);

    seq_state_t         state_q;
    logic [5:0]         ratio_q;
    logic [4:0]         acq_q;
    logic [CNT_W-1:0]   clk_cnt_q;
    logic [1:0]         mode_q;
    logic               temp_q;
    logic               cont_q;
    logic [DATA_W-1:0]  data_q;
    logic               stat_q;

    logic               idle;
    logic               is_temp;
    logic               trig;
    logic               launch;
    logic [CNT_W-1:0]   total_clks;
    logic               last_clk;
    logic               acq_end;
    logic               sign_fill;

    assign idle       = (state_q == SEQ_IDLE);
    assign is_temp    = (chan == CH_W'(TEMP_CHAN));
    assign trig       = pwr_on && ((start_en && (soft_pulse || pin_req)) || cont_q);
    assign launch     = idle && trig;
    assign total_clks = CNT_W'(acq_q) + CNT_W'(EXTRA_CLKS);
    assign last_clk   = tick && (clk_cnt_q == total_clks - CNT_W'(1));
    assign acq_end    = tick && (state_q == SEQ_ACQ) && (clk_cnt_q == CNT_W'(acq_q) - CNT_W'(1));
    assign sign_fill  = (mode_q == MODE_DIFF) && sample_in[RES_W-1];

    // Phase sequencing and launch-time capture of the effective timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            ratio_q   <= 6'd1;
            acq_q     <= 5'd2;
            clk_cnt_q <= '0;
            mode_q    <= '0;
            temp_q    <= 1'b0;
        end else if (idle) begin
            if (launch) begin
                state_q   <= SEQ_ACQ;
                clk_cnt_q <= '0;
                ratio_q   <= is_temp ? 6'd32 : div_ratio(div_code);
                acq_q     <= is_temp ? 5'd16 : acq_clocks(acq_code);
                mode_q    <= mode;
                temp_q    <= is_temp;
            end
        end else if (tick) begin
            if (last_clk) begin
                state_q   <= SEQ_IDLE;
                clk_cnt_q <= '0;
            end else begin
                clk_cnt_q <= clk_cnt_q + CNT_W'(1);
                if (acq_end) state_q <= SEQ_TRIAL;
            end
        end
    end

    // Continuous-run flag: armed by a launch with continuous mode on.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_on || !cont_en) cont_q <= 1'b0;
        else if (launch)                   cont_q <= 1'b1;
    end

    // Result capture and status flag (a write beats a clearing read).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            stat_q <= 1'b0;
        end else begin
            if (last_clk) data_q <= {{SIGN_W{sign_fill}}, sample_in, {LOW_W{1'b0}}};
            if (last_clk)       stat_q <= 1'b1;
            else if (data_read) stat_q <= 1'b0;
        end
    end

    assign run         = !idle;
    assign ratio       = ratio_q;
    assign busy_out    = run && busy_en;
    assign data_word   = data_q;
    assign status_flag = stat_q;

    AST_START_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(pwr_on)) else $error("launch while powered down"); // R12
    AST_STATUS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        last_clk |=> status_flag) else $error("status not set"); // R7
    AST_TEMP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (run && temp_q) |-> (ratio_q == 6'd32 && acq_q == 5'd16)) else $error("temp timing"); // R5
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last_clk) |=> (run && $stable(ratio_q) && $stable(acq_q))) else $error("restart in flight"); // R13
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (clk_cnt_q < total_clks)) else $error("clock count overrun"); // R4
    AST_RESULT_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q[LOW_W-1:0] == '0) &&
        ((data_q[DATA_W-1 -: SIGN_W] == '0) ||
         (data_q[DATA_W-1 -: SIGN_W+1] == '1))) else $error("result layout"); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
// Top: ADC conversion sequencer with register interface. Wires the
// register file, start pin conditioning, ADC clock divider and the
// conversion sequencer together. Assumes one synchronous clock domain
// apart from start_pin.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int DATA_W      = 32,
    parameter int CH_W        = 4,
    parameter int TEMP_CHAN   = 15,
    parameter int EXTRA_CLKS  = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              start_pin,
    input  logic [RES_W-1:0]  sample_in,
    output logic              adc_busy,
    output logic              adc_irq
);

    logic              soft_pulse, data_read, pin_req, tick, run;
    logic [CH_W-1:0]   chan;
    logic              edge_mode, start_en, busy_en, pwr_on, cont_en;
    logic [2:0]        div_code;
    logic [1:0]        acq_code, mode;
    logic [5:0]        ratio;
    logic [DATA_W-1:0] data_word;
    logic              status_flag;

    adc_ctrl_regs #(.CH_W(CH_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .data_word(data_word),
        .status_flag(status_flag), .bus_rdata(bus_rdata),
        .soft_pulse(soft_pulse), .data_read(data_read), .chan(chan),
        .edge_mode(edge_mode), .div_code(div_code), .acq_code(acq_code),
        .start_en(start_en), .busy_en(busy_en), .pwr_on(pwr_on),
        .mode(mode), .cont_en(cont_en)
    );

    adc_start_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst_n(rst_n), .pin(start_pin),
        .edge_mode(edge_mode), .pin_req(pin_req)
    );

    adc_clk_div #(.RATIO_W(6)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .ratio(ratio), .tick(tick)
    );

    adc_conv_seq #(
        .RES_W(RES_W), .DATA_W(DATA_W), .CH_W(CH_W),
        .TEMP_CHAN(TEMP_CHAN), .EXTRA_CLKS(EXTRA_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .soft_pulse(soft_pulse), .pin_req(pin_req),
        .chan(chan), .div_code(div_code), .acq_code(acq_code),
        .start_en(start_en), .busy_en(busy_en), .pwr_on(pwr_on),
        .mode(mode), .cont_en(cont_en), .sample_in(sample_in),
        .data_read(data_read), .tick(tick), .run(run), .ratio(ratio),
        .busy_out(adc_busy), .data_word(data_word), .status_flag(status_flag)
    );

    assign adc_irq = status_flag;

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

    localparam logic [15:0] PWR  = 16'h0020;
    localparam logic [15:0] BEN  = 16'h0040;
    localparam logic [15:0] SEN  = 16'h0080;
    localparam logic [15:0] SOFT = 16'h0001;
    localparam logic [15:0] CONT = 16'h0002;
    localparam logic [15:0] EDGE = 16'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [31:0] bus_rdata;
    logic        start_pin = 1'b0;
    logic [11:0] sample_in = 12'd0;
    logic        adc_busy, adc_irq;

    int n_chk = 0, n_fail = 0, busy_cyc = 0, done_cnt = 0, cyc = 0;
    logic busy_prev = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .start_pin(start_pin), .sample_in(sample_in),
        .adc_busy(adc_busy), .adc_irq(adc_irq)
    );

    // Busy-cycle and completed-conversion monitor.
    always @(negedge clk) begin
        if (adc_busy) busy_cyc++;
        if (busy_prev && !adc_busy) done_cnt++;
        busy_prev = adc_busy;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (done_cnt < target && t < 4000) begin @(negedge clk); t++; end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One software-started conversion; returns busy cycles seen.
    task automatic soft_conv(input logic [15:0] ctl, output int cycles);
        int b0, d0;
        b0 = busy_cyc; d0 = done_cnt;
        wr(2'd0, ctl | SOFT);
        wait_done(d0 + 1);
        cycles = busy_cyc - b0;
    endtask

    // Expected result word.
    function automatic logic [31:0] fmt(input logic [11:0] s, input logic [1:0] m);
        return {{4{(m == 2'b01) & s[11]}}, s, 16'h0000};
    endfunction

    initial begin
        logic [31:0] r;
        int c, d0, d1, b0;

        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, r); chk("R1 ctrl reset", r, 32'h0600);
        rd(2'd1, r); chk("R1 chan reset", r, 0);
        rd(2'd2, r); chk("R1 data reset", r, 0);
        rd(2'd3, r); chk("R1 status reset", r, 0);
        chk("R1 busy reset", {31'd0, adc_busy}, 0);
        chk("R1 irq reset", {31'd0, adc_irq}, 0);
        wr(2'd0, 16'hFFFE); rd(2'd0, r); chk("R1 ctrl stored bits", r, 32'h3FFA);
        idle_cycles(10);
        chk("R1 no start from readback write", done_cnt, 0);
        wr(2'd0, 16'h0600);

        // R2/R3/R4/R6/R7/R8: sweep every divider and acquisition code
        for (int dc = 0; dc < 8; dc++) begin
            for (int ac = 0; ac < 4; ac++) begin
                logic [11:0] s;
                int dv, nv;
                s = 12'((dc * 293 + ac * 611 + 5) & 'hFFF);
                sample_in = s;
                dv = (dc >= 5) ? 32 : (1 << dc);
                nv = 2 << ac;
                soft_conv(PWR | BEN | SEN | 16'(dc << 10) | 16'(ac << 8), c);
                chk("R2/R3/R4/R8 busy length", c, dv * (nv + 19));
                rd(2'd3, r); chk("R7 status set", r, 1);
                chk("R7 irq set", {31'd0, adc_irq}, 1);
                rd(2'd2, r); chk("R6 straight result", r, fmt(s, 2'b00));
                rd(2'd3, r); chk("R7 status cleared", r, 0);
                chk("R7 irq cleared", {31'd0, adc_irq}, 0);
            end
        end

        // R5: temperature channel override then user timing again
        wr(2'd1, 16'd15);
        soft_conv(PWR | BEN | SEN, c); chk("R5 temp timing", c, 32 * 35);
        wr(2'd1, 16'd3);
        soft_conv(PWR | BEN | SEN, c); chk("R5 user timing after temp", c, 21);
        rd(2'd1, r); chk("R5 chan readback", r, 3);

        // R6: encodings by mode
        sample_in = 12'h800; soft_conv(PWR | BEN | SEN | 16'h0008, c);
        rd(2'd2, r); chk("R6 diff negative", r, 32'hF800_0000);
        sample_in = 12'h7FF; soft_conv(PWR | BEN | SEN | 16'h0008, c);
        rd(2'd2, r); chk("R6 diff positive", r, 32'h07FF_0000);
        sample_in = 12'hFFF; soft_conv(PWR | BEN | SEN | 16'h0008, c);
        rd(2'd2, r); chk("R6 diff minus one", r, 32'hFFFF_0000);
        sample_in = 12'h800; soft_conv(PWR | BEN | SEN | 16'h0010, c);
        rd(2'd2, r); chk("R6 pseudo diff", r, 32'h0800_0000);
        sample_in = 12'hFFF; soft_conv(PWR | BEN | SEN | 16'h0018, c);
        rd(2'd2, r); chk("R6 reserved mode", r, 32'h0FFF_0000);

        // R4: busy output hidden when bit 6 clear, conversion still runs
        b0 = busy_cyc;
        wr(2'd0, PWR | SEN | SOFT);
        idle_cycles(40);
        chk("R4 busy hidden", busy_cyc - b0, 0);
        rd(2'd3, r); chk("R4 conversion ran unseen", r, 1);
        rd(2'd2, r);

        // R13: second start during conversion ignored
        b0 = busy_cyc; d0 = done_cnt;
        wr(2'd0, PWR | BEN | SEN | SOFT | 16'h0400);
        idle_cycles(10);
        wr(2'd0, PWR | BEN | SEN | SOFT);
        wait_done(d0 + 1);
        idle_cycles(60);
        chk("R13 timing unchanged", busy_cyc - b0, 42);
        chk("R13 no queued start", done_cnt - d0, 1);

        // R12: powered down, no start
        b0 = busy_cyc; d0 = done_cnt;
        wr(2'd0, BEN | SEN | SOFT);
        start_pin = 1'b1; idle_cycles(50); start_pin = 1'b0;
        chk("R12 no busy when off", busy_cyc - b0, 0);
        chk("R12 no conversion when off", done_cnt - d0, 0);

        // R9: edge trigger
        wr(2'd0, PWR | BEN | SEN | EDGE);
        d0 = done_cnt;
        @(negedge clk); start_pin = 1'b1;
        idle_cycles(2);
        chk("R9 busy before third edge", {31'd0, adc_busy}, 0);
        idle_cycles(1);
        chk("R9 busy after third edge", {31'd0, adc_busy}, 1);
        idle_cycles(100);
        chk("R9 one conversion per edge", done_cnt - d0, 1);
        start_pin = 1'b0; idle_cycles(5);
        start_pin = 1'b1; idle_cycles(60); start_pin = 1'b0;
        chk("R9 second edge", done_cnt - d0, 2);

        // R10: level trigger
        wr(2'd0, PWR | BEN | SEN);
        d0 = done_cnt;
        start_pin = 1'b1; idle_cycles(100); start_pin = 1'b0;
        idle_cycles(40);
        chk("R10 repeated conversions", {31'd0, done_cnt - d0 >= 4}, 1);
        d1 = done_cnt; idle_cycles(60);
        chk("R10 stops after pin low", done_cnt - d1, 0);

        // R11: continuous mode survives clearing start enable
        wr(2'd0, PWR | BEN | SEN | CONT | SOFT);
        idle_cycles(50);
        wr(2'd0, PWR | BEN | CONT);
        d1 = done_cnt; idle_cycles(50);
        chk("R11 continues without enable", {31'd0, done_cnt - d1 >= 2}, 1);
        wr(2'd0, PWR | BEN);
        idle_cycles(40);
        d1 = done_cnt; idle_cycles(60);
        chk("R11 stops when cleared", done_cnt - d1, 0);
        chk("R11 idle after stop", {31'd0, adc_busy}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule